// File: doc/BRIEF.md
# Memory Operation Issue Queue

This block holds decoded memory operations between dispatch and the address-generation pipeline. Up to two operations arrive per cycle in program order. Each one carries a load/store kind, two address-operand tags with ready bits, a store-data tag with its own ready bit, and an opaque identifier. Result broadcasts on the wakeup ports mark matching operands as ready. Each cycle the queue can send out one load and one store on separate outputs. Each output reports the entry index and the identifier.

The ordering policy is asymmetric. Loads may overtake other loads, and the oldest ready one wins. A load never overtakes a store that is still waiting. Stores leave strictly in program order. A store needs only its address operands to be ready. Its data readiness is passed along on the output so that later stages can wait for the data.

Program age comes from a ring with an oldest pointer and a next-free pointer. Issued entries are reclaimed from the oldest end. A flush empties the queue.

Top module: `mem_issue_queue`

## Requirements
- R1: `disp_full` is high exactly when fewer than 2 of the 16 entries are free. A dispatch presented while `disp_full` is high is dropped in both slots.
- R2: Valid dispatch slots fill consecutive ring entries starting at the next-free pointer, and slot 0 is older than slot 1. A lone valid slot 1 takes a single entry. After reset or flush, allocation starts at entry 0. The issue outputs report the entry index and the identifier given at dispatch.
- R3: At most one load and at most one store issue per cycle. They use separate outputs and never name the same entry.
- R4: A load never issues while any older store in the queue has not issued.
- R5: Among loads whose address operands are ready and that have no older pending store, the oldest issues. A younger ready load passes an older load that is still waiting.
- R6: Only the oldest unissued store may issue, and only once both of its address operands are ready.
- R7: A store's data readiness never delays it. `st_dat_rdy` shows the entry's data-ready bit on the cycle the store issues (1 = data ready).
- R8: A wakeup tag sets every matching operand ready at the clock edge. This includes operands dispatched in that same cycle. An entry woken in a cycle, or dispatched with ready operands in a cycle, can be selected from the next cycle on.
- R9: While `flush` is high, nothing issues and any dispatch is dropped. From the next cycle the queue is empty and allocation restarts at entry 0.
- R10: Issued entries are released from the oldest end, at most 2 per cycle, no earlier than the cycle after they issue. An issued entry behind an unissued one stays allocated.
- R11: After reset the queue is empty, nothing issues and `disp_full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all entries |
| disp_valid | input | DISP_W | Per-slot dispatch valid, slot 0 oldest |
| disp_is_store | input | DISP_W | 1 = store, 0 = load |
| disp_src_tag | input | DISP_W*NSRC*TAG_W | Address operand tags, slot-major |
| disp_src_rdy | input | DISP_W*NSRC | Address operand ready at dispatch |
| disp_dat_tag | input | DISP_W*TAG_W | Store data tag |
| disp_dat_rdy | input | DISP_W | Store data ready at dispatch |
| disp_id | input | DISP_W*ID_W | Opaque operation identifier |
| wake_valid | input | WAKE_N | Wakeup broadcast valid |
| wake_tag | input | WAKE_N*TAG_W | Wakeup broadcast tags |
| disp_full | output | 1 | Dispatch must hold |
| ld_valid | output | 1 | A load issues this cycle |
| ld_idx | output | IDX_W | Entry index of the issuing load |
| ld_id | output | ID_W | Identifier of the issuing load |
| st_valid | output | 1 | A store issues this cycle |
| st_idx | output | IDX_W | Entry index of the issuing store |
| st_id | output | ID_W | Identifier of the issuing store |
| st_dat_rdy | output | 1 | Data-ready bit of the issuing store |

## Verification
The bench builds the queue with the default depth of 16, dispatch width 2, two address operands and two wakeup ports. It narrows the tags to 4 bits, so random broadcasts often match waiting operands and tags are often shared by several entries. With 16 entries, directed filling reaches the full threshold, the ring wraps many times during random traffic, and a stalled store can hold back a long run of younger loads. Random flushes at about one cycle in a hundred restart allocation at every occupancy level.

// File: rtl/mem_iq_pkg.sv
package mem_iq_pkg;

  typedef enum logic {OP_LOAD = 1'b0, OP_STORE = 1'b1} mem_op_e;

  // position reached by stepping ofs entries forward from base on the ring
  function automatic int unsigned ring_add(int unsigned base, int unsigned ofs,
                                           int unsigned depth);
    return (base + ofs) % depth;
  endfunction

  // distance of an entry from the oldest pointer: 0 is the oldest
  function automatic int unsigned ring_age(int unsigned idx, int unsigned head,
                                           int unsigned depth);
    return (idx + depth - head) % depth;
  endfunction

endpackage

// File: rtl/mem_iq_pick.sv
module mem_iq_pick
  import mem_iq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [IDX_W-1:0] head,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] age
);

  // scan from youngest to oldest so the last hit kept is the oldest one
  always_comb begin
    int unsigned j;
    found = 1'b0;
    idx   = '0;
    age   = '0;
    j     = 0;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      j = ring_add(32'(head), 32'(a), DEPTH);
      if (req[j]) begin
        found = 1'b1;
        idx   = IDX_W'(j);
        age   = IDX_W'(a);
      end
    end
  end

endmodule

// File: rtl/mem_iq_slot.sv
module mem_iq_slot
  import mem_iq_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int NSRC   = 2,
  parameter int WAKE_N = 2,
  parameter int ID_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    alloc,
  input  logic                    alloc_store,
  input  logic [NSRC*TAG_W-1:0]   alloc_src_tag,
  input  logic [NSRC-1:0]         alloc_src_rdy,
  input  logic [TAG_W-1:0]        alloc_dat_tag,
  input  logic                    alloc_dat_rdy,
  input  logic [ID_W-1:0]         alloc_id,
  input  logic [WAKE_N-1:0]       wake_valid,
  input  logic [WAKE_N*TAG_W-1:0] wake_tag,
  input  logic                    issue,
  input  logic                    retire_i,
  output logic                    valid_o,
  output logic                    store_o,
  output logic                    issued_o,
  output logic                    addr_rdy_o,
  output logic                    dat_rdy_o,
  output logic [ID_W-1:0]         id_o
);

  logic                  valid_q, issued_q, dat_rdy_q;
  mem_op_e               op_q;
  logic [NSRC*TAG_W-1:0] src_tag_q;
  logic [NSRC-1:0]       src_rdy_q;
  logic [TAG_W-1:0]      dat_tag_q;
  logic [ID_W-1:0]       id_q;

  function automatic logic woken(input logic [TAG_W-1:0] t);
    logic h;
    h = 1'b0;
    for (int w = 0; w < WAKE_N; w++)
      if (wake_valid[w] && wake_tag[w*TAG_W +: TAG_W] == t) h = 1'b1;
    return h;
  endfunction

  // wakeup hits for stored operands and for operands arriving this cycle
  logic [NSRC-1:0] held_hit, new_hit;
  logic            held_dat_hit, new_dat_hit;
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      held_hit[s] = woken(src_tag_q[s*TAG_W +: TAG_W]);
      new_hit[s]  = woken(alloc_src_tag[s*TAG_W +: TAG_W]);
    end
    held_dat_hit = woken(dat_tag_q);
    new_dat_hit  = woken(alloc_dat_tag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      issued_q  <= 1'b0;
      op_q      <= OP_LOAD;
      src_tag_q <= '0;
      src_rdy_q <= '0;
      dat_tag_q <= '0;
      dat_rdy_q <= 1'b0;
      id_q      <= '0;
    end else if (flush) begin
      valid_q  <= 1'b0;
      issued_q <= 1'b0;
    end else if (alloc) begin
      valid_q   <= 1'b1;
      issued_q  <= 1'b0;
      op_q      <= mem_op_e'(alloc_store);
      src_tag_q <= alloc_src_tag;
      src_rdy_q <= alloc_src_rdy | new_hit;
      dat_tag_q <= alloc_dat_tag;
      dat_rdy_q <= alloc_dat_rdy | new_dat_hit;
      id_q      <= alloc_id;
    end else begin
      if (retire_i) valid_q <= 1'b0;
      if (issue) issued_q <= 1'b1;
      src_rdy_q <= src_rdy_q | held_hit;
      dat_rdy_q <= dat_rdy_q | held_dat_hit;
    end
  end

  assign valid_o    = valid_q;
  assign store_o    = (op_q == OP_STORE);
  assign issued_o   = issued_q;
  assign addr_rdy_o = &src_rdy_q;
  assign dat_rdy_o  = dat_rdy_q;
  assign id_o       = id_q;

  // R2: allocation only ever lands on a free entry
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !valid_q);
  // R3: an entry is selected at most once while it lives
  p_issue_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (valid_q && !issued_q));
  // R10: release only removes entries that have already issued
  p_retire_issued_r10: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |-> (valid_q && issued_q));

endmodule

// File: rtl/mem_issue_queue.sv
module mem_issue_queue
  import mem_iq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 2,
  parameter int NSRC   = 2,
  parameter int WAKE_N = 2,
  parameter int TAG_W  = 6,
  parameter int ID_W   = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic [DISP_W-1:0]              disp_valid,
  input  logic [DISP_W-1:0]              disp_is_store,
  input  logic [DISP_W*NSRC*TAG_W-1:0]   disp_src_tag,
  input  logic [DISP_W*NSRC-1:0]         disp_src_rdy,
  input  logic [DISP_W*TAG_W-1:0]        disp_dat_tag,
  input  logic [DISP_W-1:0]              disp_dat_rdy,
  input  logic [DISP_W*ID_W-1:0]         disp_id,
  input  logic [WAKE_N-1:0]              wake_valid,
  input  logic [WAKE_N*TAG_W-1:0]        wake_tag,
  output logic                           disp_full,
  output logic                           ld_valid,
  output logic [IDX_W-1:0]               ld_idx,
  output logic [ID_W-1:0]                ld_id,
  output logic                           st_valid,
  output logic [IDX_W-1:0]               st_idx,
  output logic [ID_W-1:0]                st_id,
  output logic                           st_dat_rdy
);

  logic [IDX_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt;

  // per-entry state seen from outside the slots
  logic [DEPTH-1:0] s_valid, s_store, s_issued, s_addr_rdy, s_dat_rdy;
  logic [ID_W-1:0]  s_id [DEPTH];

  // ---------------- dispatch steering ----------------
  logic                  disp_ok;
  logic [CNT_W-1:0]      n_disp;
  logic [DEPTH-1:0]      a_vec, a_st, a_drdy;
  logic [NSRC*TAG_W-1:0] a_stag [DEPTH];
  logic [NSRC-1:0]       a_srdy [DEPTH];
  logic [TAG_W-1:0]      a_dtag [DEPTH];
  logic [ID_W-1:0]       a_id   [DEPTH];

  assign disp_full = (DEPTH - int'(cnt)) < DISP_W;
  assign disp_ok   = !disp_full && !flush;

  always_comb begin
    int unsigned ofs, tgt;
    ofs    = 0;
    tgt    = 0;
    a_vec  = '0;
    a_st   = '0;
    a_drdy = '0;
    for (int e = 0; e < DEPTH; e++) begin
      a_stag[e] = '0;
      a_srdy[e] = '0;
      a_dtag[e] = '0;
      a_id[e]   = '0;
    end
    for (int k = 0; k < DISP_W; k++) begin
      if (disp_ok && disp_valid[k]) begin
        tgt          = ring_add(32'(tail), ofs, DEPTH);
        a_vec[tgt]   = 1'b1;
        a_st[tgt]    = disp_is_store[k];
        a_drdy[tgt]  = disp_dat_rdy[k];
        a_stag[tgt]  = disp_src_tag[k*NSRC*TAG_W +: NSRC*TAG_W];
        a_srdy[tgt]  = disp_src_rdy[k*NSRC +: NSRC];
        a_dtag[tgt]  = disp_dat_tag[k*TAG_W +: TAG_W];
        a_id[tgt]    = disp_id[k*ID_W +: ID_W];
        ofs          = ofs + 1;
      end
    end
    n_disp = CNT_W'(ofs);
  end

  // ---------------- selection ----------------
  logic             os_found, ld_found;
  logic [IDX_W-1:0] os_idx, os_age, ld_pick_idx, ld_age;
  logic [DEPTH-1:0] req_st, req_ld, issue_vec, retire_vec;

  mem_iq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_st (
    .req(req_st), .head(head), .found(os_found), .idx(os_idx), .age(os_age));

  mem_iq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick_ld (
    .req(req_ld), .head(head), .found(ld_found), .idx(ld_pick_idx), .age(ld_age));

  assign st_valid   = os_found && s_addr_rdy[os_idx] && !flush;
  assign st_idx     = os_idx;
  assign st_id      = s_id[os_idx];
  assign st_dat_rdy = s_dat_rdy[os_idx];
  assign ld_valid   = ld_found && !flush;
  assign ld_idx     = ld_pick_idx;
  assign ld_id      = s_id[ld_pick_idx];

  // ---------------- release from the oldest end ----------------
  logic [CNT_W-1:0] n_ret;
  always_comb begin
    logic        run;
    int unsigned at;
    run        = 1'b1;
    at         = 0;
    n_ret      = '0;
    retire_vec = '0;
    for (int r = 0; r < DISP_W; r++) begin
      at = ring_add(32'(head), 32'(r), DEPTH);
      if (run && (r < int'(cnt)) && s_issued[at]) begin
        retire_vec[at] = 1'b1;
        n_ret          = n_ret + 1'b1;
      end else begin
        run = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else if (flush) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      head <= IDX_W'(ring_add(32'(head), 32'(n_ret), DEPTH));
      tail <= IDX_W'(ring_add(32'(tail), 32'(n_disp), DEPTH));
      cnt  <= cnt + n_disp - n_ret;
    end
  end

  // ---------------- entry array ----------------
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    assign req_st[e] = s_valid[e] && s_store[e] && !s_issued[e];
    assign req_ld[e] = s_valid[e] && !s_store[e] && !s_issued[e] && s_addr_rdy[e] &&
                       (!os_found || IDX_W'(ring_age(e, 32'(head), DEPTH)) < os_age);
    assign issue_vec[e] = (ld_valid && ld_pick_idx == IDX_W'(e)) ||
                          (st_valid && os_idx == IDX_W'(e));

    mem_iq_slot #(.TAG_W(TAG_W), .NSRC(NSRC), .WAKE_N(WAKE_N), .ID_W(ID_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .alloc(a_vec[e]), .alloc_store(a_st[e]), .alloc_src_tag(a_stag[e]),
      .alloc_src_rdy(a_srdy[e]), .alloc_dat_tag(a_dtag[e]), .alloc_dat_rdy(a_drdy[e]),
      .alloc_id(a_id[e]), .wake_valid(wake_valid), .wake_tag(wake_tag),
      .issue(issue_vec[e]), .retire_i(retire_vec[e]),
      .valid_o(s_valid[e]), .store_o(s_store[e]), .issued_o(s_issued[e]),
      .addr_rdy_o(s_addr_rdy[e]), .dat_rdy_o(s_dat_rdy[e]), .id_o(s_id[e]));
  end

  // ---------------- assertion support: independent age scan ----------------
  logic older_st_vs_ld, older_st_vs_st;
  always_comb begin
    int unsigned ag;
    ag             = 0;
    older_st_vs_ld = 1'b0;
    older_st_vs_st = 1'b0;
    for (int e = 0; e < DEPTH; e++) begin
      ag = ring_age(32'(e), 32'(head), DEPTH);
      if (s_valid[e] && s_store[e] && !s_issued[e]) begin
        if (ag < 32'(ld_age)) older_st_vs_ld = 1'b1;
        if (ag < 32'(os_age)) older_st_vs_st = 1'b1;
      end
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_full && !flush) |=> (cnt <= $past(cnt)));
  p_two_ports_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && st_valid) |-> (ld_idx != st_idx));
  p_ld_no_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> !older_st_vs_ld);
  p_ld_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (s_addr_rdy[ld_idx] && !s_store[ld_idx] && s_valid[ld_idx]));
  p_st_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (!older_st_vs_st && s_addr_rdy[st_idx] && s_store[st_idx]));
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && !ld_valid && !st_valid));

endmodule

// File: tb/mem_issue_queue_tb.sv
module mem_issue_queue_tb_top;
  localparam int DEPTH = 16, DISP_W = 2, NSRC = 2, WAKE_N = 2, TAG_W = 4, ID_W = 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [DISP_W-1:0]            disp_valid = '0, disp_is_store = '0, disp_dat_rdy = '0;
  logic [DISP_W*NSRC*TAG_W-1:0] disp_src_tag = '0;
  logic [DISP_W*NSRC-1:0]       disp_src_rdy = '0;
  logic [DISP_W*TAG_W-1:0]      disp_dat_tag = '0;
  logic [DISP_W*ID_W-1:0]       disp_id = '0;
  logic [WAKE_N-1:0]            wake_valid = '0;
  logic [WAKE_N*TAG_W-1:0]      wake_tag = '0;
  logic disp_full, ld_valid, st_valid, st_dat_rdy;
  logic [IDX_W-1:0] ld_idx, st_idx;
  logic [ID_W-1:0]  ld_id, st_id;

  mem_issue_queue #(.DEPTH(DEPTH), .DISP_W(DISP_W), .NSRC(NSRC), .WAKE_N(WAKE_N),
                    .TAG_W(TAG_W), .ID_W(ID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid),
    .disp_is_store(disp_is_store), .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
    .disp_dat_tag(disp_dat_tag), .disp_dat_rdy(disp_dat_rdy), .disp_id(disp_id),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .disp_full(disp_full),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_id(ld_id), .st_valid(st_valid),
    .st_idx(st_idx), .st_id(st_id), .st_dat_rdy(st_dat_rdy));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, nid = 1;
  bit done = 1'b0;

  // program-order reference: position 0 is the oldest live entry
  int             m_n = 0, m_tail = 0;
  int             m_slot [DEPTH];
  int             m_id   [DEPTH];
  bit             m_st   [DEPTH];
  bit             m_iss  [DEPTH];
  bit             m_drdy [DEPTH];
  logic [TAG_W-1:0] m_dtag [DEPTH];
  logic [TAG_W-1:0] m_tag  [DEPTH][NSRC];
  bit             m_rdy  [DEPTH][NSRC];

  task automatic chk(string lbl, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", lbl, act, exp, $time);
    end
  endtask

  function automatic bit bcast(logic [TAG_W-1:0] t);
    bit h = 1'b0;
    for (int w = 0; w < WAKE_N; w++)
      if (wake_valid[w] && wake_tag[w*TAG_W +: TAG_W] == t) h = 1'b1;
    return h;
  endfunction

  function automatic bit all_rdy(int p);
    bit r = 1'b1;
    for (int s = 0; s < NSRC; s++) r &= m_rdy[p][s];
    return r;
  endfunction

  // one clock: entered just after a falling edge with inputs applied
  task automatic step();
    int os, lk, nret;
    bit exp_full, exp_st, exp_ld;
    #1;
    exp_full = (DEPTH - m_n) < DISP_W;                 // R1, R10 (occupancy)
    os = -1;
    for (int p = m_n - 1; p >= 0; p--) if (m_st[p] && !m_iss[p]) os = p;
    exp_st = (os >= 0) && all_rdy(os) && !flush;       // R6, R7, R9
    lk = -1;
    for (int p = ((os < 0) ? m_n : os) - 1; p >= 0; p--)
      if (!m_st[p] && !m_iss[p] && all_rdy(p)) lk = p; // R4, R5
    exp_ld = (lk >= 0) && !flush;

    chk("R1/R10 disp_full", int'(disp_full), int'(exp_full));
    chk(flush ? "R9 store issue during flush" : "R6/R8 store issue", int'(st_valid), int'(exp_st));
    chk(flush ? "R9 load issue during flush" : "R4/R5/R8 load issue", int'(ld_valid), int'(exp_ld));
    if (exp_st && st_valid) begin
      chk("R2 store entry index", int'(st_idx), m_slot[os]);
      chk("R2 store id", int'(st_id), m_id[os]);
      chk("R7 store data ready flag", int'(st_dat_rdy), int'(m_drdy[os]));
    end
    if (exp_ld && ld_valid) begin
      chk("R2 load entry index", int'(ld_idx), m_slot[lk]);
      chk("R2 load id", int'(ld_id), m_id[lk]);
    end
    if (ld_valid && st_valid) chk("R3 distinct entries", int'(ld_idx == st_idx), 0);

    if (flush) begin
      m_n = 0; m_tail = 0;
    end else begin
      nret = 0;                                        // R10 uses pre-issue state
      for (int p = 0; p < DISP_W; p++)
        if (p < m_n && p == nret && m_iss[p]) nret++;
      if (exp_st) m_iss[os] = 1'b1;
      if (exp_ld) m_iss[lk] = 1'b1;
      for (int p = 0; p < m_n; p++) begin              // R8
        for (int s = 0; s < NSRC; s++) if (bcast(m_tag[p][s])) m_rdy[p][s] = 1'b1;
        if (bcast(m_dtag[p])) m_drdy[p] = 1'b1;
      end
      for (int p = 0; p + nret < m_n; p++) begin
        m_slot[p] = m_slot[p+nret]; m_id[p] = m_id[p+nret]; m_st[p] = m_st[p+nret];
        m_iss[p] = m_iss[p+nret]; m_drdy[p] = m_drdy[p+nret]; m_dtag[p] = m_dtag[p+nret];
        for (int s = 0; s < NSRC; s++) begin
          m_tag[p][s] = m_tag[p+nret][s]; m_rdy[p][s] = m_rdy[p+nret][s];
        end
      end
      m_n -= nret;
      if (!exp_full) begin                             // R1, R2
        for (int k = 0; k < DISP_W; k++) if (disp_valid[k]) begin
          m_slot[m_n] = m_tail % DEPTH; m_tail++;
          m_id[m_n]   = int'(disp_id[k*ID_W +: ID_W]);
          m_st[m_n]   = disp_is_store[k];
          m_iss[m_n]  = 1'b0;
          m_dtag[m_n] = disp_dat_tag[k*TAG_W +: TAG_W];
          m_drdy[m_n] = disp_dat_rdy[k] | bcast(m_dtag[m_n]);
          for (int s = 0; s < NSRC; s++) begin
            m_tag[m_n][s] = disp_src_tag[(k*NSRC+s)*TAG_W +: TAG_W];
            m_rdy[m_n][s] = disp_src_rdy[k*NSRC+s] | bcast(m_tag[m_n][s]);
          end
          m_n++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; disp_valid = '0; wake_valid = '0;
  endtask

  task automatic put(int k, bit st, int t0, bit r0, int t1, bit r1, int dt, bit dr);
    disp_valid[k] = 1'b1; disp_is_store[k] = st;
    disp_src_tag[(k*NSRC)*TAG_W +: TAG_W]   = TAG_W'(t0); disp_src_rdy[k*NSRC]   = r0;
    disp_src_tag[(k*NSRC+1)*TAG_W +: TAG_W] = TAG_W'(t1); disp_src_rdy[k*NSRC+1] = r1;
    disp_dat_tag[k*TAG_W +: TAG_W] = TAG_W'(dt); disp_dat_rdy[k] = dr;
    disp_id[k*ID_W +: ID_W] = ID_W'(nid); nid++;
  endtask

  task automatic wake(int t);
    wake_valid = '0; wake_valid[0] = 1'b1; wake_tag[0 +: TAG_W] = TAG_W'(t);
  endtask

  task automatic rand_cycle();
    idle();
    flush = ($urandom % 100) < 1;
    for (int k = 0; k < DISP_W; k++)
      if (($urandom % 100) < 55)
        put(k, ($urandom % 100) < 40, $urandom % 16, ($urandom % 100) < 50,
            $urandom % 16, ($urandom % 100) < 60, $urandom % 16, ($urandom % 100) < 50);
    for (int w = 0; w < WAKE_N; w++) begin
      wake_valid[w] = ($urandom % 100) < 45;
      wake_tag[w*TAG_W +: TAG_W] = TAG_W'($urandom % 16);
    end
    step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset ld_valid", int'(ld_valid), 0);
    chk("R11 reset st_valid", int'(st_valid), 0);
    chk("R11 reset disp_full", int'(disp_full), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R8: ready load stuck behind a store waiting on tag 3
    idle(); put(0, 1, 3, 0, 3, 0, 2, 1); put(1, 0, 1, 1, 1, 1, 0, 0); step();
    idle(); repeat (3) step();
    idle(); wake(3); step();
    idle(); repeat (3) step();

    // R5: younger ready load passes older waiting load (tag 7)
    idle(); put(0, 0, 7, 0, 1, 1, 0, 0); put(1, 0, 1, 1, 1, 1, 0, 0); step();
    idle(); step(); step();
    idle(); wake(7); step();
    idle(); repeat (2) step();

    // R7: store issues with data not ready; R2 lone slot 1
    idle(); put(1, 1, 1, 1, 1, 1, 9, 0); step();
    idle(); step(); step();

    // R1: fill with waiting loads, dispatch while full is dropped
    for (int c = 0; c < 10; c++) begin
      idle(); put(0, 0, 12, 0, 12, 0, 0, 0); put(1, 0, 12, 0, 12, 0, 0, 0); step();
    end
    // R9: flush with a dispatch present, then allocation restarts at entry 0
    idle(); flush = 1'b1; put(0, 1, 1, 1, 1, 1, 0, 1); step();
    idle(); put(0, 1, 1, 1, 1, 1, 0, 1); step();
    idle(); repeat (2) step();

    // R10: issued loads behind an unissued one stay until it issues
    idle(); put(0, 0, 5, 0, 5, 0, 0, 0); put(1, 0, 1, 1, 1, 1, 0, 0); step();
    idle(); repeat (2) step();
    idle(); wake(5); step();
    idle(); repeat (3) step();

    for (int c = 0; c < 4000; c++) rand_cycle();

    idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule